// File: doc/BRIEF.md
# Flash Program and Erase Command Sequencer

This block drives a parallel flash that reports progress through a status byte read back from the array. A requester hands it one operation at a time: erase a block, program one word, program a burst of words through the device's write buffer, or set or clear a block's lock. The operation comes with a target address, a data word and, for bursts, a word count. The sequencer issues the command writes on a single-cycle flash write strobe. It then reads status each cycle until the ready bit comes up or a cycle budget runs out, and turns the error bits into a result code. Every operation ends with a read-array command, written in the same cycle as a one-cycle done pulse that carries the result.

The flash port is a simple synchronous strobe interface. `fl_wr` or `fl_rd` is high for one cycle with `fl_addr`. The read data `fl_rdata` is taken in the same cycle as `fl_rd`. Burst words are fetched from the requester through a word index output, `wd_idx`, with `wd_data` returned combinationally.

States: IDLE (waiting, `req_ready` high), CHECK (reads the old word before a single-word program), CLR (clear-status command), SETUP (operation setup command), WAITB (polls for buffer availability), COUNT (writes count minus one), DATA (writes data words), CONF (confirm or lock-mode command), POLL (polls for completion), EXIT (read-array command and done). Transitions:
- IDLE→CHECK for a program request, IDLE→CLR for the other valid requests, and IDLE→EXIT for an unknown opcode.
- CHECK→EXIT if the word is not erased enough, otherwise CHECK→CLR. CLR→SETUP.
- SETUP→WAITB for a burst, SETUP→DATA for a single program, SETUP→CONF otherwise.
- WAITB→COUNT when ready, WAITB→EXIT on timeout. COUNT→DATA.
- DATA→POLL for a single program, DATA→DATA while burst words remain, DATA→CONF after the last burst word. CONF→POLL.
- POLL→EXIT when ready or on timeout. EXIT→IDLE.

Top module: `fseq_top`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0 and no flash strobe is active; `fl_wr` and `fl_rd` are never high together.
- R2: Opcode 0 (erase) writes 0x50, 0x20 and 0xD0 to `req_addr` in consecutive cycles, then polls status at `req_addr`.
- R3: Opcode 1 (program) first reads the word at `req_addr`. If `req_data` has a 1 where that word has a 0, the operation ends with no write other than 0xFF, with result NOT_ERASED (2), two cycles after acceptance.
- R4: An accepted program writes 0x50 and 0x40 to `req_addr`, then `req_data` to `req_addr`, then polls.
- R5: Opcode 2 (burst) writes 0x50 and 0xE8 and polls until status bit 7 is set. It then writes `req_cnt`−1, then data word i (i = 0 to `req_cnt`−1, taken from `wd_data` while `wd_idx` = i) to `req_addr`+i, then 0xD0, then polls. All writes other than the data go to `req_addr`.
- R6: Opcode 3 (lock) writes 0x50, 0x60, 0x01 and opcode 4 (unlock) writes 0x50, 0x60, 0xD0 to `req_addr`, then polls.
- R7: Status bit 7 clear means busy. Polling reads once per cycle, and the first read with bit 7 set ends the wait in that cycle.
- R8: If `TMO` consecutive status reads in one wait show busy, the operation ends with result TIMEOUT (1) and the read-array write.
- R9: On completion, bit 1 gives PROTECTED (3). Otherwise bits 5 and 4 together give INVALID (4), bit 5 alone gives NOT_ERASED (2), and bit 4 or bit 3 gives INVALID (4). With none of these bits set the result is OK (0). Error bits seen while waiting for the write buffer are ignored.
- R10: Each operation ends with a write of 0x00FF to `req_addr`, in the same cycle as a one-cycle `done` pulse with `result` valid.
- R11: `req_ready` is low from the cycle after acceptance until the cycle after `done`; requests presented meanwhile have no effect on the writes or result.
- R12: Opcodes 5 to 7 end in the cycle after acceptance with result INVALID (4) and only the 0xFF write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | High in idle; request taken when both high |
| req_op | input | 3 | Opcode (0 erase, 1 program, 2 burst, 3 lock, 4 unlock) |
| req_addr | input | AW | Target address |
| req_data | input | DW | Word for single program |
| req_cnt | input | CW | Burst word count (1 or more) |
| wd_idx | output | CW | Index of the burst word wanted |
| wd_data | input | DW | Burst word at `wd_idx` |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code, valid with `done` |
| fl_wr | output | 1 | Flash write strobe |
| fl_rd | output | 1 | Flash read strobe |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data, same cycle as `fl_rd` |

## Verification
Counting the accepting edge as edge 1, with B busy reads per wait, `done` rises after these edges:
- erase, lock and unlock: 5+B;
- program: 6+B, or 2 when the program is rejected;
- burst of N words: 7+2B+N, since the flash model reloads its busy count on every write;
- unknown opcode: 1;
- timeout: 4+TMO for erase and lock, 5+TMO for program, 3+TMO for a buffer wait.

The bench counts edges from acceptance while sampling on falling edges, and compares the count against these formulas for every operation. It reads the write log one edge after `done`, so the final read-array write has been captured.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam logic [2:0] OP_ERASE  = 3'd0;
    localparam logic [2:0] OP_PROG   = 3'd1;
    localparam logic [2:0] OP_BURST  = 3'd2;
    localparam logic [2:0] OP_LOCK   = 3'd3;
    localparam logic [2:0] OP_UNLOCK = 3'd4;

    localparam logic [7:0] CMD_CLR     = 8'h50;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_PROG    = 8'h40;
    localparam logic [7:0] CMD_BURST   = 8'hE8;
    localparam logic [7:0] CMD_LOCKSEL = 8'h60;
    localparam logic [7:0] CMD_LOCKON  = 8'h01;
    localparam logic [7:0] CMD_READ    = 8'hFF;

    typedef enum logic [2:0] {
        RES_OK         = 3'd0,
        RES_TIMEOUT    = 3'd1,
        RES_NOT_ERASED = 3'd2,
        RES_PROTECTED  = 3'd3,
        RES_INVALID    = 3'd4
    } res_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CHECK, S_CLR, S_SETUP, S_WAITB,
        S_COUNT, S_DATA, S_CONF, S_POLL, S_EXIT
    } state_e;

endpackage

// File: rtl/fseq_status_eval.sv
module fseq_status_eval
    import fseq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] status,
    output logic          ready,
    output res_e          code
);
    always_comb begin
        ready = status[7];
        if (status[1])                    code = RES_PROTECTED;
        else if (status[5] && status[4])  code = RES_INVALID;
        else if (status[5])               code = RES_NOT_ERASED;
        else if (status[4] || status[3])  code = RES_INVALID;
        else                              code = RES_OK;
    end
endmodule

// File: rtl/fseq_poll_timer.sv
module fseq_poll_timer #(
    parameter int TMO = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic last
);
    localparam int TW = $clog2(TMO + 1);

    logic [TW-1:0] cnt;

    assign last = (cnt == TW'(TMO - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (tick)  cnt <= cnt + TW'(1);
    end
endmodule

// File: rtl/fseq_top.sv
module fseq_top
    import fseq_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CW  = 5,
    parameter int TMO = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [CW-1:0] req_cnt,
    output logic [CW-1:0] wd_idx,
    input  logic [DW-1:0] wd_data,
    output logic          done,
    output logic [2:0]    result,
    output logic          fl_wr,
    output logic          fl_rd,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic [DW-1:0] fl_rdata
);
    state_e        state;
    logic [2:0]    op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] idx_q;
    res_e          res_q;

    logic          st_ready;
    res_e          st_code;
    logic          waiting;
    logic          tmr_last;
    logic [7:0]    setup_cmd;
    logic [7:0]    conf_cmd;
    logic          op_known;
    logic          last_word;

    fseq_status_eval #(.DW(DW)) u_eval (
        .status (fl_rdata),
        .ready  (st_ready),
        .code   (st_code)
    );

    assign waiting = (state == S_WAITB) || (state == S_POLL);

    fseq_poll_timer #(.TMO(TMO)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!waiting),
        .tick  (waiting && !st_ready),
        .last  (tmr_last)
    );

    assign op_known  = (req_op <= OP_UNLOCK);
    assign last_word = (idx_q == cnt_q - CW'(1));
    assign result    = res_q;
    assign wd_idx    = idx_q;

    always_comb begin
        unique case (op_q)
            OP_ERASE:          setup_cmd = CMD_ERASE;
            OP_PROG:           setup_cmd = CMD_PROG;
            OP_BURST:          setup_cmd = CMD_BURST;
            default:           setup_cmd = CMD_LOCKSEL;
        endcase
        conf_cmd = (op_q == OP_LOCK) ? CMD_LOCKON : CMD_CONFIRM;
    end

    // State register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_q   <= '0;
            addr_q <= '0;
            data_q <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            res_q  <= RES_OK;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    op_q   <= req_op;
                    addr_q <= req_addr;
                    data_q <= req_data;
                    cnt_q  <= req_cnt;
                    idx_q  <= '0;
                    res_q  <= RES_OK;
                    if (!op_known) begin
                        res_q <= RES_INVALID;
                        state <= S_EXIT;
                    end else if (req_op == OP_PROG) begin
                        state <= S_CHECK;
                    end else begin
                        state <= S_CLR;
                    end
                end
                S_CHECK: begin
                    if ((data_q & ~fl_rdata) != '0) begin
                        res_q <= RES_NOT_ERASED;
                        state <= S_EXIT;
                    end else begin
                        state <= S_CLR;
                    end
                end
                S_CLR:   state <= S_SETUP;
                S_SETUP: begin
                    if (op_q == OP_BURST)     state <= S_WAITB;
                    else if (op_q == OP_PROG) state <= S_DATA;
                    else                      state <= S_CONF;
                end
                S_WAITB: begin
                    if (st_ready) begin
                        state <= S_COUNT;
                    end else if (tmr_last) begin
                        res_q <= RES_TIMEOUT;
                        state <= S_EXIT;
                    end
                end
                S_COUNT: state <= S_DATA;
                S_DATA: begin
                    if (op_q == OP_PROG) begin
                        state <= S_POLL;
                    end else if (last_word) begin
                        state <= S_CONF;
                    end else begin
                        idx_q <= idx_q + CW'(1);
                    end
                end
                S_CONF:  state <= S_POLL;
                S_POLL: begin
                    if (st_ready) begin
                        res_q <= st_code;
                        state <= S_EXIT;
                    end else if (tmr_last) begin
                        res_q <= RES_TIMEOUT;
                        state <= S_EXIT;
                    end
                end
                S_EXIT:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Outputs per state
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        fl_wr     = 1'b0;
        fl_rd     = 1'b0;
        fl_addr   = addr_q;
        fl_wdata  = '0;
        unique case (state)
            S_IDLE:  req_ready = 1'b1;
            S_CHECK, S_WAITB, S_POLL: fl_rd = 1'b1;
            S_CLR: begin
                fl_wr    = 1'b1;
                fl_wdata = DW'(CMD_CLR);
            end
            S_SETUP: begin
                fl_wr    = 1'b1;
                fl_wdata = DW'(setup_cmd);
            end
            S_COUNT: begin
                fl_wr    = 1'b1;
                fl_wdata = DW'(cnt_q - CW'(1));
            end
            S_DATA: begin
                fl_wr = 1'b1;
                if (op_q == OP_PROG) begin
                    fl_wdata = data_q;
                end else begin
                    fl_addr  = addr_q + AW'(idx_q);
                    fl_wdata = wd_data;
                end
            end
            S_CONF: begin
                fl_wr    = 1'b1;
                fl_wdata = DW'(conf_cmd);
            end
            S_EXIT: begin
                fl_wr    = 1'b1;
                fl_wdata = DW'(CMD_READ);
                done     = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          done,
    input logic [2:0]    result,
    input logic          fl_wr,
    input logic          fl_rd,
    input logic [DW-1:0] fl_wdata
);
    a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_wr && fl_rd));

    a_r10_done_with_read_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fl_wr && fl_wdata == DW'(8'hFF)));

    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r11_not_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

    a_r9_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result <= 3'd4));

    a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);
endmodule

bind fseq_top fseq_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .result    (result),
    .fl_wr     (fl_wr),
    .fl_rd     (fl_rd),
    .fl_wdata  (fl_wdata)
);

// File: tb/fseq_top_test.sv
`timescale 1ns/1ps
module fseq_top_test;
    localparam int AW = 16, DW = 16, CW = 5, TMO = 12;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [2:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [CW-1:0] req_cnt = '0;
    logic [CW-1:0] wd_idx;
    logic [DW-1:0] wd_data;
    logic done;
    logic [2:0] result;
    logic fl_wr, fl_rd;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata, fl_rdata;

    fseq_top #(.AW(AW), .DW(DW), .CW(CW), .TMO(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_cnt(req_cnt),
        .wd_idx(wd_idx), .wd_data(wd_data), .done(done), .result(result),
        .fl_wr(fl_wr), .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata)
    );

    // Flash model: array mode after 0xFF, status mode after any other write
    logic [15:0] mem [16];
    logic [15:0] bw [32];
    logic        amode = 1'b1;
    int          busy_left = 0;
    int          cfg_busy = 0;
    logic [7:0]  cfg_err = 8'h00;
    logic [15:0] lg_a [2048];
    logic [15:0] lg_d [2048];
    int          lg_n = 0;

    assign wd_data  = bw[wd_idx];
    assign fl_rdata = amode ? mem[fl_addr[3:0]]
                            : {8'h00, (busy_left > 0) ? 1'b0 : 1'b1, cfg_err[6:0]};

    always @(posedge clk) begin
        if (fl_wr) begin
            if (lg_n < 2048) begin
                lg_a[lg_n] <= fl_addr;
                lg_d[lg_n] <= fl_wdata;
            end
            lg_n      <= lg_n + 1;
            amode     <= (fl_wdata == 16'h00FF);
            busy_left <= cfg_busy;
        end else if (fl_rd && !amode && busy_left > 0) begin
            busy_left <= busy_left - 1;
        end
    end

    int total = 0, bad = 0;
    logic [15:0] ex_a [64];
    logic [15:0] ex_d [64];
    int ex_n;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] a, input logic [15:0] d);
        ex_a[ex_n] = a;
        ex_d[ex_n] = d;
        ex_n++;
    endtask

    function automatic logic [2:0] dec_exp(input logic [7:0] e);
        if (e[1])              return 3'd3;
        if (e[5] && e[4])      return 3'd4;
        if (e[5])              return 3'd2;
        if (e[4] || e[3])      return 3'd4;
        return 3'd0;
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [15:0] addr,
                          input logic [15:0] data, input int cnt,
                          input int busy, input logic [7:0] err, input string req);
        int exp_lat, lat, base, nw;
        logic [2:0] exp_res;
        logic seen, same;
        ex_n = 0;
        cfg_busy = busy;
        cfg_err  = err;
        case (op)
            3'd0, 3'd3, 3'd4: begin
                push(addr, 16'h0050);
                push(addr, (op == 3'd0) ? 16'h0020 : 16'h0060);
                push(addr, (op == 3'd3) ? 16'h0001 : 16'h00D0);
                if (busy >= TMO) begin exp_res = 3'd1; exp_lat = 4 + TMO; end
                else begin exp_res = dec_exp(err); exp_lat = 5 + busy; end
            end
            3'd1: begin
                if ((data & ~mem[addr[3:0]]) != 16'h0) begin
                    exp_res = 3'd2; exp_lat = 2;
                end else begin
                    push(addr, 16'h0050);
                    push(addr, 16'h0040);
                    push(addr, data);
                    if (busy >= TMO) begin exp_res = 3'd1; exp_lat = 5 + TMO; end
                    else begin exp_res = dec_exp(err); exp_lat = 6 + busy; end
                end
            end
            3'd2: begin
                push(addr, 16'h0050);
                push(addr, 16'h00E8);
                if (busy >= TMO) begin
                    exp_res = 3'd1; exp_lat = 3 + TMO;
                end else begin
                    push(addr, 16'(cnt - 1));
                    for (int i = 0; i < cnt; i++) push(addr + 16'(i), bw[i]);
                    push(addr, 16'h00D0);
                    exp_res = dec_exp(err);
                    exp_lat = 7 + 2 * busy + cnt;
                end
            end
            default: begin exp_res = 3'd4; exp_lat = 1; end
        endcase
        push(addr, 16'h00FF);

        @(negedge clk);
        req_valid = 1'b1;
        req_op = op; req_addr = addr; req_data = data; req_cnt = CW'(cnt);
        base = lg_n;
        @(negedge clk);
        // keep a scrambled request present while busy (R11)
        req_op = 3'($urandom); req_addr = 16'($urandom);
        req_data = 16'($urandom); req_cnt = CW'($urandom);
        lat = 1;
        chk(req_ready == 1'b0, "R11", "ready after accept", req_ready, 0);
        seen = 1'b0;
        while (!seen && lat < 400) begin
            if (done) seen = 1'b1;
            else begin @(negedge clk); lat++; end
        end
        chk(seen && lat == exp_lat, req, "done latency (R7)", lat, exp_lat);
        chk(result == exp_res, req, "result (R9)", result, exp_res);
        chk(fl_wr && fl_wdata == 16'h00FF, "R10", "read-array write with done",
            fl_wdata, 16'h00FF);
        req_valid = 1'b0;
        @(negedge clk);
        nw = lg_n - base;
        same = (nw == ex_n);
        for (int i = 0; i < ex_n && same; i++)
            if (lg_a[base + i] != ex_a[i] || lg_d[base + i] != ex_d[i]) begin
                same = 1'b0;
                $display("FAIL %s write %0d: actual=%0h@%0h expected=%0h@%0h", req, i,
                         lg_d[base + i], lg_a[base + i], ex_d[i], ex_a[i]);
            end
        chk(same, req, "write sequence count", nw, ex_n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] a, d;
        int op, cnt, busy;
        logic [7:0] err;
        void'($urandom(32'd20240613));
        for (int i = 0; i < 16; i++) mem[i] = 16'($urandom) | 16'h0100;
        for (int i = 0; i < 32; i++) bw[i] = 16'($urandom) | 16'h0200;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !fl_wr && !fl_rd, "R1", "reset state",
            {req_ready, done, fl_wr, fl_rd}, 4'b1000);

        // directed corner cases
        run_op(3'd0, 16'h0040, 16'h0, 1, 0, 8'h00, "R2");
        run_op(3'd0, 16'h0123, 16'h0, 1, 3, 8'h20, "R9");
        run_op(3'd0, 16'h0200, 16'h0, 1, 1, 8'h30, "R9");
        run_op(3'd0, 16'h0201, 16'h0, 1, 2, 8'h22, "R9");
        run_op(3'd3, 16'h0202, 16'h0, 1, 0, 8'h08, "R9");
        run_op(3'd4, 16'h0203, 16'h0, 1, 1, 8'h10, "R9");
        run_op(3'd0, 16'h0300, 16'h0, 1, TMO - 1, 8'h00, "R7");
        run_op(3'd0, 16'h0301, 16'h0, 1, TMO, 8'h00, "R8");
        run_op(3'd1, 16'h0005, mem[5] & 16'h0F0F, 1, 2, 8'h00, "R4");
        run_op(3'd1, 16'h0006, ~mem[6], 1, 0, 8'h00, "R3");
        run_op(3'd1, 16'h0007, mem[7], 1, TMO, 8'h00, "R8");
        run_op(3'd2, 16'h0400, 16'h0, 1, 0, 8'h00, "R5");
        run_op(3'd2, 16'h0410, 16'h0, 8, 2, 8'h20, "R5");
        run_op(3'd2, 16'h0420, 16'h0, 4, TMO, 8'h00, "R8");
        run_op(3'd3, 16'h0500, 16'h0, 1, 1, 8'h00, "R6");
        run_op(3'd4, 16'h0501, 16'h0, 1, 1, 8'h00, "R6");
        run_op(3'd5, 16'h0600, 16'h0, 1, 0, 8'h00, "R12");
        run_op(3'd7, 16'h0601, 16'h0, 1, 0, 8'h00, "R12");

        // constrained random operations
        for (int n = 0; n < 60; n++) begin
            op   = $urandom_range(0, 5);
            a    = 16'($urandom);
            cnt  = $urandom_range(1, 8);
            busy = ($urandom_range(0, 9) == 0) ? TMO : $urandom_range(0, 4);
            err  = ($urandom_range(0, 2) == 0) ? (8'($urandom) & 8'h3A) : 8'h00;
            if ($urandom_range(0, 1) == 0) d = mem[a[3:0]] & 16'($urandom);
            else                           d = 16'($urandom);
            if (d == 16'h00FF) d = 16'h0000;
            case (op)
                0:       run_op(3'd0, a, d, cnt, busy, err, "R2");
                1:       run_op(3'd1, a, d, cnt, busy, err, "R4");
                2:       run_op(3'd2, a, d, cnt, busy, err, "R5");
                3:       run_op(3'd3, a, d, cnt, busy, err, "R6");
                4:       run_op(3'd4, a, d, cnt, busy, err, "R6");
                default: run_op(3'd6, a, d, cnt, busy, err, "R12");
            endcase
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule